// File: doc/BRIEF.md
# AC-link Playback Stream Slot Decoder

This block is the receiving end of the serial playback stream of an AC-link codec interface. It samples the serial data line one bit per bit-clock period, finds each frame from the rising edge of the frame-sync line, and reads the 16-bit tag word at the start of every frame. From the tag it takes the frame-valid flag, one valid flag per payload slot, and the two-bit codec address. It then delivers the command address, the command data and one left/right pair of 16-bit PCM samples with a one-cycle strobe at the end of each complete frame.

The block is clocked by `clk`. The integrator drives `clk` from the inverted bit clock, so every rising edge of `clk` falls on a falling edge of the bit clock. A strapped input `codec_id` selects which slot pair carries the PCM samples. For any non-zero ID it also makes command acceptance depend on an address match in the tag. Each frame is 256 bits: a 16-bit tag followed by twelve 20-bit slots, every word sent most significant bit first.

The controller `acl_frame_fsm` has three states:
- `ST_HUNT` waits for a sync rise.
- `ST_TAG` counts the 16 tag bits.
- `ST_SLOT` counts the twelve payload slots.

Its transitions are:
- *lock*: `ST_HUNT` to `ST_TAG` on a sync rise.
- *tag_done*: `ST_TAG` to `ST_SLOT` after the last tag bit.
- *chain*: `ST_SLOT` to `ST_TAG` when a sync rise coincides with the last bit of slot 12.
- *lose*: `ST_SLOT` to `ST_HUNT` when the last bit arrives without a sync rise.
- *resync*: `ST_TAG` or `ST_SLOT` to `ST_TAG` on a sync rise at any other bit.

Top module: `acl_out_decoder`

## Requirements
- R1: A frame is 256 samples, MSB first: tag bit 15 is the first sample after the sample in which `sync_in` is first seen high, followed by tag bits 14..0, then slots 1 to 12 of 20 bits each. `frame_stb` is high for exactly the one cycle after the sample of the frame's last bit.
- R2: Before the first sync rise after reset, and after a frame whose last bit is not accompanied by a sync rise, `sdata_in` is ignored and no `frame_stb` is produced until the next sync rise.
- R3: A sync rise seen in the same sample as the last bit of slot 12 completes that frame and starts the next one with no gap between them.
- R4: A sync rise seen at any other bit of a frame produces a one-cycle `resync` pulse. The partial frame produces no `frame_stb`, and a new frame starts at the next sample.
- R5: `frame_vld` equals tag bit 15. When it is 0, `addr_vld`, `data_vld`, `left_vld` and `right_vld` are all 0.
- R6: Tag bit 15-k is the valid flag of slot k. `cmd_addr` comes from slot 1 (flag in tag bit 14) and `cmd_data` from slot 2 (flag in tag bit 13). Any field whose valid flag is 0 reads as zero at the strobe.
- R7: With `codec_id` = 00, commands are accepted whatever tag bits 1:0 hold. With any other `codec_id`, `addr_vld` and `data_vld` also need tag bits 1:0 to equal `codec_id`. PCM acceptance does not depend on that match.
- R8: The PCM pair is taken from slots 3/4 for `codec_id` 00 or 01, from slots 7/8 for 10, and from slots 6/9 for 11. Each PCM output is bits 19..4 of its slot.
- R9: Tag bits 5 to 2 have no effect on any output.
- R10: After reset, every output is 0 and the decoder is hunting for sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (inverted bit clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| codec_id | input | 2 | Strapped codec address |
| sync_in | input | 1 | Frame sync line |
| sdata_in | input | 1 | Serial playback data line |
| frame_stb | output | 1 | One-cycle strobe after a complete frame |
| frame_vld | output | 1 | Tag frame-valid bit of the last frame |
| resync | output | 1 | One-cycle pulse on an early sync rise |
| addr_vld | output | 1 | Command address accepted |
| cmd_addr | output | 20 | Command address slot |
| data_vld | output | 1 | Command data accepted |
| cmd_data | output | 20 | Command data slot |
| left_vld | output | 1 | Left PCM sample accepted |
| pcm_left | output | 16 | Left PCM sample |
| right_vld | output | 1 | Right PCM sample accepted |
| pcm_right | output | 16 | Right PCM sample |

## Verification
The assertions check on every cycle the rules that can be seen at the ports:
- strobes last one cycle;
- completed frames are at least 256 cycles apart;
- `resync` and `frame_stb` never fire together;
- an invalid frame carries no accepted field;
- a rejected field reads as zero.

The bench scenarios show what depends on the serial content:
- which slot feeds which output for each codec ID;
- address matching;
- the ignored tag bits;
- chained frames;
- loss of lock;
- recovery after an early sync.

// File: rtl/acl_pkg.sv
package acl_pkg;

    localparam int SLOT_IDX_W = 4;

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_TAG  = 2'd1,
        ST_SLOT = 2'd2
    } acl_state_e;

    localparam logic [1:0] PRIMARY_ID = 2'b00;

    // Slot carrying the left (right = 0) or right (right = 1) PCM word.
    function automatic slot_idx_t pcm_slot(input logic [1:0] id, input logic right);
        slot_idx_t s;
        case (id)
            2'b10:   s = right ? slot_idx_t'(8) : slot_idx_t'(7);
            2'b11:   s = right ? slot_idx_t'(9) : slot_idx_t'(6);
            default: s = right ? slot_idx_t'(4) : slot_idx_t'(3);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/acl_frame_fsm.sv
module acl_frame_fsm
    import acl_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 13
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_in,
    output logic      take,
    output logic      word_end,
    output slot_idx_t slot_no,
    output logic      frame_end,
    output logic      resync
);

    localparam int MAX_W = (SLOT_W > TAG_W) ? SLOT_W : TAG_W;
    localparam int POS_W = $clog2(MAX_W);
    localparam logic [POS_W-1:0] TAG_LAST  = POS_W'(TAG_W - 1);
    localparam logic [POS_W-1:0] SLOT_LAST = POS_W'(SLOT_W - 1);
    localparam slot_idx_t        FINAL_SLOT = slot_idx_t'(NUM_SLOTS - 1);

    acl_state_e       state_q, state_d;
    slot_idx_t        slot_q, slot_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             sync_q;
    logic             rise;
    logic             in_frame;
    logic             word_last;
    logic             frame_last;
    logic             early;

    assign rise = sync_in & ~sync_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            slot_q  <= '0;
            pos_q   <= '0;
            sync_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            pos_q   <= pos_d;
            sync_q  <= sync_in;
        end
    end

    // outputs
    always_comb begin
        in_frame = (state_q != ST_HUNT);
        unique case (state_q)
            ST_TAG:  word_last = (pos_q == TAG_LAST);
            ST_SLOT: word_last = (pos_q == SLOT_LAST);
            default: word_last = 1'b0;
        endcase
        frame_last = word_last && (state_q == ST_SLOT) && (slot_q == FINAL_SLOT);
        early      = in_frame && rise && !frame_last;
        take       = in_frame && !early;
        word_end   = word_last && take;
        frame_end  = frame_last;
        resync     = early;
        slot_no    = slot_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_HUNT: begin
                if (rise) begin
                    state_d = ST_TAG;
                    slot_d  = '0;
                    pos_d   = '0;
                end
            end
            ST_TAG: begin
                if (early) begin
                    state_d = ST_TAG;
                    slot_d  = '0;
                    pos_d   = '0;
                end else if (word_last) begin
                    state_d = ST_SLOT;
                    slot_d  = slot_idx_t'(1);
                    pos_d   = '0;
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            ST_SLOT: begin
                if (early) begin
                    state_d = ST_TAG;
                    slot_d  = '0;
                    pos_d   = '0;
                end else if (frame_last) begin
                    state_d = rise ? ST_TAG : ST_HUNT;
                    slot_d  = '0;
                    pos_d   = '0;
                end else if (word_last) begin
                    slot_d = slot_q + 1'b1;
                    pos_d  = '0;
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_HUNT;
                slot_d  = '0;
                pos_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/acl_slot_shift.sv
module acl_slot_shift #(
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              sdata_in,
    output logic [SLOT_W-1:0] word
);

    logic [SLOT_W-2:0] sh_q;

    // Word completed by the bit sampled this cycle.
    assign word = {sh_q, sdata_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (take) begin
            sh_q <= word[SLOT_W-2:0];
        end
    end

endmodule

// File: rtl/acl_slot_capture.sv
module acl_slot_capture
    import acl_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int PCM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        codec_id,
    input  logic              word_end,
    input  slot_idx_t         slot_no,
    input  logic [SLOT_W-1:0] word,
    output logic [TAG_W-1:0]  tag_q,
    output logic [SLOT_W-1:0] addr_q,
    output logic [SLOT_W-1:0] data_q,
    output logic [PCM_W-1:0]  left_q,
    output logic [PCM_W-1:0]  right_q
);

    localparam int NUM_CMD = 2;
    localparam int NUM_PCM = 2;

    logic [SLOT_W-1:0] cmd_q [NUM_CMD];
    logic [PCM_W-1:0]  pcm_q [NUM_PCM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (word_end && slot_no == '0) begin
            tag_q <= word[TAG_W-1:0];
        end
    end

    // command slots 1 and 2 sit at fixed positions
    for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
        localparam slot_idx_t CMD_SLOT = slot_idx_t'(g + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmd_q[g] <= '0;
            end else if (word_end && slot_no == CMD_SLOT) begin
                cmd_q[g] <= word;
            end
        end
    end

    // PCM slots depend on the strapped codec ID
    for (genvar g = 0; g < NUM_PCM; g++) begin : g_pcm
        slot_idx_t pick;
        assign pick = pcm_slot(codec_id, g[0]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pcm_q[g] <= '0;
            end else if (word_end && slot_no == pick) begin
                pcm_q[g] <= word[SLOT_W-1 -: PCM_W];
            end
        end
    end

    assign addr_q  = cmd_q[0];
    assign data_q  = cmd_q[1];
    assign left_q  = pcm_q[0];
    assign right_q = pcm_q[1];

endmodule

// File: rtl/acl_out_decoder.sv
module acl_out_decoder
    import acl_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 13,
    parameter int PCM_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        codec_id,
    input  logic              sync_in,
    input  logic              sdata_in,
    output logic              frame_stb,
    output logic              frame_vld,
    output logic              resync,
    output logic              addr_vld,
    output logic [SLOT_W-1:0] cmd_addr,
    output logic              data_vld,
    output logic [SLOT_W-1:0] cmd_data,
    output logic              left_vld,
    output logic [PCM_W-1:0]  pcm_left,
    output logic              right_vld,
    output logic [PCM_W-1:0]  pcm_right
);

    logic              take;
    logic              word_end;
    slot_idx_t         slot_no;
    logic              frame_end;
    logic              resync_w;
    logic [SLOT_W-1:0] word;
    logic [TAG_W-1:0]  tag_q;
    logic [SLOT_W-1:0] addr_q, data_q;
    logic [PCM_W-1:0]  left_q, right_q;
    logic [NUM_SLOTS-1:0] slot_flag;
    logic              id_ok;
    logic              av_d, dv_d, lv_d, rv_d;
    logic              unused_bits;

    acl_frame_fsm #(
        .TAG_W     (TAG_W),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .take      (take),
        .word_end  (word_end),
        .slot_no   (slot_no),
        .frame_end (frame_end),
        .resync    (resync_w)
    );

    acl_slot_shift #(
        .SLOT_W (SLOT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .sdata_in (sdata_in),
        .word     (word)
    );

    acl_slot_capture #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .PCM_W  (PCM_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .codec_id (codec_id),
        .word_end (word_end),
        .slot_no  (slot_no),
        .word     (word),
        .tag_q    (tag_q),
        .addr_q   (addr_q),
        .data_q   (data_q),
        .left_q   (left_q),
        .right_q  (right_q)
    );

    // per-slot acceptance, gated by the frame-valid bit
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_flag
        if (k == 0) begin : g_frame
            assign slot_flag[k] = tag_q[TAG_W-1];
        end else begin : g_slot
            assign slot_flag[k] = tag_q[TAG_W-1] & tag_q[TAG_W-1-k];
        end
    end

    always_comb begin
        id_ok = (codec_id == PRIMARY_ID) || (tag_q[1:0] == codec_id);
        av_d  = slot_flag[1] & id_ok;
        dv_d  = slot_flag[2] & id_ok;
        lv_d  = slot_flag[pcm_slot(codec_id, 1'b0)];
        rv_d  = slot_flag[pcm_slot(codec_id, 1'b1)];
    end

    assign unused_bits = ^{slot_flag, tag_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_stb <= 1'b0;
            frame_vld <= 1'b0;
            resync    <= 1'b0;
            addr_vld  <= 1'b0;
            cmd_addr  <= '0;
            data_vld  <= 1'b0;
            cmd_data  <= '0;
            left_vld  <= 1'b0;
            pcm_left  <= '0;
            right_vld <= 1'b0;
            pcm_right <= '0;
        end else begin
            frame_stb <= frame_end;
            resync    <= resync_w;
            if (frame_end) begin
                frame_vld <= slot_flag[0];
                addr_vld  <= av_d;
                cmd_addr  <= av_d ? addr_q : '0;
                data_vld  <= dv_d;
                cmd_data  <= dv_d ? data_q : '0;
                left_vld  <= lv_d;
                pcm_left  <= lv_d ? left_q : '0;
                right_vld <= rv_d;
                pcm_right <= rv_d ? right_q : '0;
            end
        end
    end

endmodule

// File: rtl/acl_out_decoder_chk.sv
module acl_out_decoder_chk #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 13,
    parameter int PCM_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        codec_id,
    input logic              sync_in,
    input logic              sdata_in,
    input logic              frame_stb,
    input logic              frame_vld,
    input logic              resync,
    input logic              addr_vld,
    input logic [SLOT_W-1:0] cmd_addr,
    input logic              data_vld,
    input logic [SLOT_W-1:0] cmd_data,
    input logic              left_vld,
    input logic [PCM_W-1:0]  pcm_left,
    input logic              right_vld,
    input logic [PCM_W-1:0]  pcm_right
);

    localparam int FRAME_BITS = TAG_W + (NUM_SLOTS - 1) * SLOT_W;

    logic [15:0] gap_q;
    logic        unused_in;

    assign unused_in = ^{codec_id, sync_in, sdata_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (frame_stb) begin
            gap_q <= '0;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    assert_stb_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> gap_q >= 16'(FRAME_BITS - 1));

    assert_stb_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    assert_resync_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !resync);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(resync && frame_stb));

    assert_invalid_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !frame_vld) |-> !(addr_vld || data_vld || left_vld || right_vld));

    assert_cmd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> ((addr_vld || cmd_addr == '0) && (data_vld || cmd_data == '0)));

    assert_pcm_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> ((left_vld || pcm_left == '0) && (right_vld || pcm_right == '0)));

endmodule

bind acl_out_decoder acl_out_decoder_chk #(
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS),
    .PCM_W     (PCM_W)
) u_chk (.*);

// File: tb/test_acl_out_decoder.sv
module test_acl_out_decoder;

    localparam int TAG_W = 16, SLOT_W = 20, NUM_SLOTS = 13, PCM_W = 16;
    localparam int FRAME_BITS = 256;
    localparam int NVEC = 12;

    // {codec_id, tag, seed, expected {frame,addr,data,left,right}}
    localparam logic [38:0] VEC [NVEC] = '{
        {2'd0, 16'hFFC0, 16'h1234, 5'b11111},
        {2'd0, 16'h7FC0, 16'h2222, 5'b00000},
        {2'd0, 16'hE000, 16'h3333, 5'b11100},
        {2'd0, 16'h9803, 16'h4444, 5'b10011},
        {2'd1, 16'hFFC1, 16'h5555, 5'b11111},
        {2'd1, 16'hFFC2, 16'h6666, 5'b10011},
        {2'd2, 16'hFFC2, 16'h7777, 5'b11111},
        {2'd2, 16'h9802, 16'h8888, 5'b10000},
        {2'd3, 16'h8243, 16'h9999, 5'b10011},
        {2'd3, 16'hFFC0, 16'hAAAA, 5'b10011},
        {2'd0, 16'hFFFC, 16'hBBBB, 5'b11111},
        {2'd3, 16'hE183, 16'hCCCC, 5'b11100}
    };
    localparam string VREQ [NVEC] = '{"R8", "R5", "R6", "R7", "R7", "R7",
                                      "R8", "R8", "R8", "R7", "R9", "R6"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        codec_id = 2'd0;
    logic              sync_in = 1'b0;
    logic              sdata_in = 1'b0;
    logic              frame_stb, frame_vld, resync;
    logic              addr_vld, data_vld, left_vld, right_vld;
    logic [SLOT_W-1:0] cmd_addr, cmd_data;
    logic [PCM_W-1:0]  pcm_left, pcm_right;

    int checks = 0;
    int errors = 0;
    int n_stb = 0;
    int n_resync = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    acl_out_decoder #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .PCM_W(PCM_W)
    ) i_acl_out_decoder (
        .clk(clk), .rst_n(rst_n), .codec_id(codec_id), .sync_in(sync_in),
        .sdata_in(sdata_in), .frame_stb(frame_stb), .frame_vld(frame_vld),
        .resync(resync), .addr_vld(addr_vld), .cmd_addr(cmd_addr),
        .data_vld(data_vld), .cmd_data(cmd_data), .left_vld(left_vld),
        .pcm_left(pcm_left), .right_vld(right_vld), .pcm_right(pcm_right)
    );

    always @(negedge clk) begin
        if (frame_stb) n_stb++;
        if (resync) n_resync++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] slot_word(input int k, input logic [15:0] seed);
        return {4'(k), seed ^ (16'(k) * 16'h0F1D)};
    endfunction

    task automatic send_frame(input logic [15:0] tag, input logic [15:0] seed,
                              input bit lead, input bit chain);
        logic [FRAME_BITS-1:0] fr;
        fr[FRAME_BITS-1 -: 16] = tag;
        for (int k = 1; k < NUM_SLOTS; k++)
            fr[FRAME_BITS-1-16-(k-1)*20 -: 20] = slot_word(k, seed);
        if (lead) begin
            @(negedge clk);
            sync_in = 1'b1;
            sdata_in = 1'b0;
        end
        for (int i = 0; i < FRAME_BITS; i++) begin
            @(negedge clk);
            sdata_in = fr[FRAME_BITS-1-i];
            sync_in = (i < 15) || (chain && i == FRAME_BITS - 1);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sync_in = 1'b0;
            sdata_in = 1'b0;
        end
    endtask

    task automatic run_vec(input int v);
        logic [1:0]  id;
        logic [15:0] tag, seed;
        logic [4:0]  e;
        int ls, rs, s0;
        {id, tag, seed, e} = VEC[v];
        case (id)
            2'd2: begin ls = 7; rs = 8; end
            2'd3: begin ls = 6; rs = 9; end
            default: begin ls = 3; rs = 4; end
        endcase
        codec_id = id;
        s0 = n_stb;
        send_frame(tag, seed, 1'b1, 1'b0);
        @(negedge clk); sync_in = 1'b0; sdata_in = 1'b0; #2;
        check("R1 strobe after last bit", 32'(frame_stb), 32'd1);
        @(negedge clk); #2;
        check("R1 strobe width", 32'(frame_stb), 32'd0);
        check("R1 one strobe", 32'(n_stb - s0), 32'd1);
        check({VREQ[v], " frame_vld"}, 32'(frame_vld), 32'(e[4]));
        check({VREQ[v], " addr_vld"}, 32'(addr_vld), 32'(e[3]));
        check({VREQ[v], " data_vld"}, 32'(data_vld), 32'(e[2]));
        check({VREQ[v], " left_vld"}, 32'(left_vld), 32'(e[1]));
        check({VREQ[v], " right_vld"}, 32'(right_vld), 32'(e[0]));
        check({VREQ[v], " cmd_addr R6"}, 32'(cmd_addr), e[3] ? 32'(slot_word(1, seed)) : 32'd0);
        check({VREQ[v], " cmd_data R6"}, 32'(cmd_data), e[2] ? 32'(slot_word(2, seed)) : 32'd0);
        check({VREQ[v], " pcm_left R8"}, 32'(pcm_left), e[1] ? 32'(slot_word(ls, seed) >> 4) : 32'd0);
        check({VREQ[v], " pcm_right R8"}, 32'(pcm_right), e[0] ? 32'(slot_word(rs, seed) >> 4) : 32'd0);
    endtask

    initial begin
        int s0, r0;
        repeat (3) @(negedge clk);
        #2;
        check("R10 frame_stb in reset", 32'(frame_stb), 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check("R10 outputs after reset",
              32'({frame_stb, frame_vld, resync, addr_vld, data_vld, left_vld, right_vld}), 32'd0);
        check("R10 fields after reset", 32'(cmd_addr | cmd_data | 20'(pcm_left) | 20'(pcm_right)), 32'd0);

        // R2: serial data without any sync rise is ignored
        s0 = n_stb;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            sdata_in = i[0] ^ i[3];
        end
        idle(2); #2;
        check("R2 no strobe before sync", 32'(n_stb - s0), 32'd0);

        for (int v = 0; v < NVEC; v++) run_vec(v);

        // R3: back-to-back frames
        codec_id = 2'd0;
        s0 = n_stb;
        send_frame(16'hFFC0, 16'h0A0A, 1'b1, 1'b1);
        send_frame(16'hFFC0, 16'h0B0B, 1'b0, 1'b0);
        idle(3); #2;
        check("R3 two chained strobes", 32'(n_stb - s0), 32'd2);
        check("R3 second frame addr", 32'(cmd_addr), 32'(slot_word(1, 16'h0B0B)));
        check("R3 second frame right", 32'(pcm_right), 32'(slot_word(4, 16'h0B0B) >> 4));

        // R2: lock lost after a frame ending without sync
        s0 = n_stb;
        send_frame(16'hFFC0, 16'h0C0C, 1'b1, 1'b0);
        for (int i = 0; i < FRAME_BITS; i++) begin
            @(negedge clk);
            sync_in = 1'b0;
            sdata_in = ~i[1];
        end
        idle(3); #2;
        check("R2 no strobe after lock lost", 32'(n_stb - s0), 32'd1);
        check("R2 fields kept from last frame", 32'(cmd_addr), 32'(slot_word(1, 16'h0C0C)));

        // R4: early sync rise aborts the partial frame
        s0 = n_stb;
        r0 = n_resync;
        @(negedge clk); sync_in = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            sync_in = (i < 15);
            sdata_in = 1'b1;
        end
        send_frame(16'hFFC0, 16'h0D0D, 1'b1, 1'b0);
        idle(3); #2;
        check("R4 one resync pulse", 32'(n_resync - r0), 32'd1);
        check("R4 only the full frame strobes", 32'(n_stb - s0), 32'd1);
        check("R4 recovered addr", 32'(cmd_addr), 32'(slot_word(1, 16'h0D0D)));
        check("R4 recovered left", 32'(pcm_left), 32'(slot_word(3, 16'h0D0D) >> 4));

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule